// File: doc/BRIEF.md
# Idle-Age Victim Selector for a Four-Way Unequal-Size Cache

This block chooses which way to evict in a four-way set-associative cache whose ways differ in size. Way 0 holds 256 lines, way 1 holds 128, way 2 holds 64 and way 3 holds 32. Every line has a small idle-age counter. An access to a line marks it valid and clears its age. A free-running prescaler issues a global tick at a fixed interval, and on each tick every line's age moves one step toward its ceiling.

When a miss needs a victim, the caller presents the miss index. Each way takes its own low-order slice of that index to find its candidate line. The block returns, in the same cycle, the way whose candidate has been idle longest. An empty candidate always wins over a filled one. Equal ages are settled by a mode input: one setting keeps recently active data in the small, fast ways by evicting from the smallest tied way, and the other evicts from the largest tied way. Tag storage, data storage and the refill path are outside this block.

Top module: `asym_decay_victim`

## Requirements
- R1: The prescaler restarts at reset and issues a tick on the 256th rising clock edge after reset is released, then on every 256th edge after that.
- R2: An access (`touch_en` high, way `touch_way`, index `touch_idx`) makes the addressed line of that way valid and sets its age to 0 on the next rising edge.
- R3: Each tick adds one to the age of every line that is not being accessed. Ages are 2 bits wide and stop at 3 instead of wrapping.
- R4: When an access and a tick land on the same line in the same cycle, the line's age afterwards is 0.
- R5: Way w (w = 0..3) holds 2^(8-w) lines, and its candidate is the line at the low 8-w bits of the index. Way 3 is the smallest way and way 0 is the largest.
- R6: `victim_way` names the way whose valid candidate has the largest age.
- R7: A candidate that is not valid is chosen before any valid candidate.
- R8: Among tied candidates, `prefer_small` = 1 selects the highest-numbered (smallest) way, and `prefer_small` = 0 selects the lowest-numbered (largest) way. This rule also applies when several candidates are invalid.
- R9: `victim_way` depends combinationally on `query_idx`, `prefer_small` and the stored state. No clock edge is needed to produce it.
- R10: Reset clears every valid bit, every age and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prefer_small | input | 1 | Tie-break mode: 1 evicts from the smallest tied way, 0 from the largest |
| touch_en | input | 1 | An access or fill occurs this cycle |
| touch_way | input | 2 | Way being accessed |
| touch_idx | input | 8 | Index of the access; each way uses its own low-order slice |
| query_idx | input | 8 | Index of the miss that needs a victim |
| victim_way | output | 2 | Way chosen for replacement |

## Verification
The hardest cases to reach from the ports are an access that falls on exactly the same edge as a tick, and a tick that arrives one edge early or one edge late. The bench keeps its own count of edges since reset. It uses this count to place one access on the edge just before the first tick and another access on the tick edge itself. It then reads the resulting age order through the victim output, where an early tick, a late tick or a tick that overrides the access each produce a different way. Saturation is reached by letting one line sit idle through enough ticks that a wrapping counter would drop it below its younger neighbours.

// File: rtl/asym_decay_victim.sv
`timescale 1ns/1ps
module asym_decay_victim #(
  parameter int NUM_WAYS    = 4,
  parameter int IDX_W       = 8,
  parameter int AGE_W       = 2,
  parameter int TICK_PERIOD = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prefer_small,
  input  logic                        touch_en,
  input  logic [$clog2(NUM_WAYS)-1:0] touch_way,
  input  logic [IDX_W-1:0]            touch_idx,
  input  logic [IDX_W-1:0]            query_idx,
  output logic [$clog2(NUM_WAYS)-1:0] victim_way
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int KEY_W = AGE_W + 1;
  localparam int PRE_W = $clog2(TICK_PERIOD);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_PERIOD - 1);
  localparam logic [AGE_W-1:0] AGE_MAX  = '1;

  logic [PRE_W-1:0] pre_q;
  logic tick;
  logic [NUM_WAYS-1:0][KEY_W-1:0] cand_key;
  logic [KEY_W-1:0] best_key;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam int IW    = IDX_W - w;
    localparam int LINES = 1 << IW;

    logic [AGE_W-1:0] age_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [IW-1:0]    t_idx, q_idx;
    logic             sel;

    assign t_idx = touch_idx[IW-1:0];
    assign q_idx = query_idx[IW-1:0];
    assign sel   = touch_en && (touch_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q   <= '{default: '0};
        valid_q <= '0;
      end else begin
        for (int i = 0; i < LINES; i++) begin
          if (sel && t_idx == IW'(i)) begin
            age_q[i]   <= '0;
            valid_q[i] <= 1'b1;
          end else if (tick && age_q[i] != AGE_MAX) begin
            age_q[i] <= age_q[i] + 1'b1;
          end
        end
      end
    end

    assign cand_key[w] = valid_q[q_idx] ? {1'b0, age_q[q_idx]} : {1'b1, {AGE_W{1'b0}}};
  end

  always_comb begin
    best_key   = cand_key[0];
    victim_way = '0;
    for (int w = 1; w < NUM_WAYS; w++) begin
      if (cand_key[w] > best_key || (prefer_small && cand_key[w] == best_key)) begin
        best_key   = cand_key[w];
        victim_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/asym_decay_victim_chk.sv
`timescale 1ns/1ps
module asym_decay_victim_chk #(
  parameter int NUM_WAYS    = 4,
  parameter int IDX_W       = 8,
  parameter int WAY_W       = 2,
  parameter int KEY_W       = 3,
  parameter int TICK_PERIOD = 256
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           tick,
  input logic                           prefer_small,
  input logic                           touch_en,
  input logic [WAY_W-1:0]               touch_way,
  input logic [IDX_W-1:0]               touch_idx,
  input logic [IDX_W-1:0]               query_idx,
  input logic [WAY_W-1:0]               victim_way,
  input logic [NUM_WAYS-1:0][KEY_W-1:0] cand_key
);
  localparam int GAP_W = $clog2(TICK_PERIOD);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(TICK_PERIOD - 1);
  localparam logic [KEY_W-1:0] SAT_KEY  = {1'b0, {(KEY_W-1){1'b1}}};

  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  p_tick_on_time_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == GAP_LAST);
  p_tick_not_late_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q == GAP_LAST |-> tick);

  p_touch_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (query_idx != $past(touch_idx) || cand_key[$past(touch_way)] == '0));

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk
    p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_key[w] == SAT_KEY && !(touch_en && touch_way == WAY_W'(w)))
      |=> (!$stable(query_idx) || cand_key[w] == SAT_KEY));
    p_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cand_key[victim_way] >= cand_key[w]);
    p_invalid_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cand_key[w][KEY_W-1] |-> cand_key[victim_way][KEY_W-1]);
    p_tie_small_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prefer_small && victim_way < WAY_W'(w)) |-> cand_key[w] < cand_key[victim_way]);
    p_tie_large_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!prefer_small && victim_way > WAY_W'(w)) |-> cand_key[w] < cand_key[victim_way]);
  end
endmodule

bind asym_decay_victim asym_decay_victim_chk #(
  .NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .KEY_W(KEY_W), .TICK_PERIOD(TICK_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .prefer_small(prefer_small),
  .touch_en(touch_en), .touch_way(touch_way), .touch_idx(touch_idx),
  .query_idx(query_idx), .victim_way(victim_way), .cand_key(cand_key)
);

// File: tb/asym_decay_victim_bench.sv
`timescale 1ns/1ps
module asym_decay_victim_bench;
  localparam int P = 256;
  localparam logic [1:0] OT = 2'd0, OW = 2'd1, OC = 2'd2;

  function automatic logic [15:0] st(input logic [1:0] op, input logic [1:0] wx,
                                     input logic m, input logic [2:0] n, input logic [7:0] a);
    return {op, wx, m, n, a};
  endfunction

  // fields: op, way or expected way, prefer_small, tick count, index
  localparam int NSTEPS = 33;
  localparam logic [15:0] STEPS [NSTEPS] = '{
    st(OC,2'd3,1'b1,3'd0,8'h00), st(OC,2'd0,1'b0,3'd0,8'h00),  // R7 R8 all invalid
    st(OT,2'd3,1'b0,3'd0,8'h00),
    st(OC,2'd2,1'b1,3'd0,8'h00), st(OC,2'd0,1'b0,3'd0,8'h00),  // R7 invalid ways tie
    st(OW,2'd0,1'b0,3'd1,8'h00),
    st(OT,2'd0,1'b0,3'd0,8'h00), st(OT,2'd1,1'b0,3'd0,8'h00),
    st(OT,2'd2,1'b0,3'd0,8'h00), st(OT,2'd3,1'b0,3'd0,8'h00),
    st(OC,2'd3,1'b1,3'd0,8'h00), st(OC,2'd0,1'b0,3'd0,8'h00),  // R2 R8 all age 0
    st(OW,2'd0,1'b0,3'd1,8'h00),
    st(OC,2'd3,1'b1,3'd0,8'h00),                                // R3 all age 1
    st(OT,2'd1,1'b0,3'd0,8'h00), st(OT,2'd2,1'b0,3'd0,8'h00),
    st(OT,2'd3,1'b0,3'd0,8'h00),
    st(OC,2'd0,1'b1,3'd0,8'h00), st(OC,2'd0,1'b0,3'd0,8'h00),  // R6 unique oldest
    st(OW,2'd0,1'b0,3'd2,8'h00),
    st(OC,2'd0,1'b1,3'd0,8'h00),                                // R3 ages 3,2,2,2
    st(OW,2'd0,1'b0,3'd1,8'h00),
    st(OC,2'd3,1'b1,3'd0,8'h00), st(OC,2'd0,1'b0,3'd0,8'h00),  // R3 saturation, no wrap
    st(OC,2'd2,1'b1,3'd0,8'h20), st(OC,2'd0,1'b0,3'd0,8'h20),  // R5 way 3 aliases line 0
    st(OC,2'd0,1'b1,3'd0,8'h80), st(OC,2'd0,1'b0,3'd0,8'h80),  // R5 only way 0 differs
    st(OW,2'd0,1'b0,3'd1,8'h00),
    st(OT,2'd0,1'b0,3'd0,8'h00), st(OT,2'd2,1'b0,3'd0,8'h00),
    st(OC,2'd3,1'b1,3'd0,8'h00), st(OC,2'd1,1'b0,3'd0,8'h00)   // R8 tie subset
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic prefer_small = 1'b1, touch_en = 1'b0;
  logic [1:0] touch_way = '0;
  logic [7:0] touch_idx = '0, query_idx = '0;
  logic [1:0] victim_way;
  int checks = 0, errors = 0, ecnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  asym_decay_victim u_asym_decay_victim (
    .clk(clk), .rst_n(rst_n), .prefer_small(prefer_small), .touch_en(touch_en),
    .touch_way(touch_way), .touch_idx(touch_idx), .query_idx(query_idx),
    .victim_way(victim_way)
  );

  task automatic touch(input logic [1:0] w, input logic [7:0] a);
    touch_en = 1'b1; touch_way = w; touch_idx = a;
    @(posedge clk);
    @(negedge clk);
    touch_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (ecnt % P != 0) @(negedge clk);
    end
  endtask

  task automatic check(input logic m, input logic [7:0] a, input logic [1:0] exp, input string tag);
    prefer_small = m; query_idx = a;
    #1;
    checks++;
    if (victim_way !== exp) begin
      errors++;
      $display("FAIL %s: idx %h mode %0d got way %0d expected %0d", tag, a, m, victim_way, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R4: tick placement after reset and access colliding with tick
    touch(2'd0, 8'hC3); touch(2'd1, 8'hC3); touch(2'd2, 8'hC3);
    while (ecnt != P - 2) @(negedge clk);
    touch(2'd3, 8'hC3);
    check(1'b1, 8'hC3, 2'd3, "R1 no tick before edge 256");
    touch(2'd0, 8'hC3);
    check(1'b0, 8'hC3, 2'd1, "R1 R4 tick at edge 256, access wins");
    check(1'b1, 8'hC3, 2'd3, "R4 R8 ages 0,1,1,1");

    for (int s = 0; s < NSTEPS; s++) begin
      automatic logic [15:0] e = STEPS[s];
      case (e[15:14])
        OT: touch(e[13:12], e[7:0]);
        OW: wait_ticks(int'(e[10:8]));
        default: check(e[11], e[7:0], e[13:12], $sformatf("step %0d R2 R3 R5 R6 R7 R8 R9", s));
      endcase
    end

    // R10: reset clears valid state
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check(1'b0, 8'h00, 2'd0, "R10 line 0 invalid after reset");
    check(1'b1, 8'h00, 2'd3, "R10 reset state, small tie");
    check(1'b0, 8'hC3, 2'd0, "R10 other lines invalid after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule